// File: doc/BRIEF.md
# Packed SIMD Multiply Unit

This block is the multiply slice of a DSP datapath. Each clock it accepts one operation on two source operands and returns a 64-bit result as a low 32-bit word and a high 32-bit word. A 3-bit operation select picks what the multiplier does. It can form a full 32x32 product, signed or unsigned. It can form two signed 16x16 products or four unsigned 8x8 products. It can add four byte products into one sum. It can perform a Q15 complex multiply, either at full precision or rounded and saturated into one packed word. Finally, it can multiply four independent byte lanes in GF(2^8).

The unit is fully pipelined. An operation presented with `in_valid` high produces its result exactly two clock edges later, together with `out_valid`. Back-to-back issue is allowed on every cycle. When no operation completes, the result words keep their last value. The source ports are `SRC_W` bits wide, but only bits [31:0] of each operand are consumed. The Galois-field reduction polynomial is a parameter that defaults to 0x1D (x^8+x^4+x^3+x^2+1).

Top module: `simd_mul_unit`

## Requirements
- R1: With op code 0, {out_hi,out_lo} is the unsigned 64-bit product of in_a[31:0] and in_b[31:0]. The low 32 product bits go to out_lo and the high 32 go to out_hi.
- R2: With op code 1, {out_hi,out_lo} is the two's-complement 64-bit product of in_a[31:0] and in_b[31:0], both taken as signed.
- R3: With op code 2, out_lo is the signed product of the [15:0] halves of the two operands and out_hi is the signed product of their [31:16] halves, each 32 bits.
- R4: With op code 3, byte lane i (bits [8i+7:8i], i = 0..3) of each operand is multiplied unsigned. The 16-bit product is placed at bits [16i+15:16i] of {out_hi,out_lo}.
- R5: With op code 4, out_lo holds the zero-extended sum of the four unsigned byte-lane products and out_hi is zero. The sum never exceeds 18 bits.
- R6: With op code 5, each operand carries a signed Q15 complex value with the real part in [31:16] and the imaginary part in [15:0]. out_lo = ar*br - ai*bi and out_hi = ar*bi + ai*br, each modulo 2^32.
- R7: With op code 6, each exact R6 result x becomes floor((x + 0x8000) / 2^16), saturated to [-32768, 32767]. out_lo[31:16] holds the real result, out_lo[15:0] holds the imaginary result, and out_hi is zero.
- R8: With op code 7, byte lane i of out_lo is the GF(2^8) product of byte lane i of the two operands, reduced by x^8 plus the 8-bit polynomial parameter (default 0x1D). out_hi is zero.
- R9: out_valid is high exactly two clock edges after a cycle with in_valid high and low otherwise. The result of that operation is present in the same cycle.
- R10: In a cycle where out_valid is low, out_lo and out_hi keep the value they had the cycle before.
- R11: Operand bits above bit 31 have no effect on any result.
- R12: While reset is active, and in the cycle after it is released, out_valid, out_lo and out_hi are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 3 | Operation select, codes 0 to 7 as in R1 to R8 |
| in_a | input | SRC_W | First source operand, bits [31:0] used |
| in_b | input | SRC_W | Second source operand, bits [31:0] used |
| out_valid | output | 1 | Result words carry a completed operation |
| out_lo | output | 32 | Low result word |
| out_hi | output | 32 | High result word |

## Verification
The checker assumes that `in_op` is always a defined 3-bit code whenever `in_valid` is high. It also assumes that inputs are free of X after reset, because the latency and hold properties compare port values two cycles apart. The stimulus drives every input at the falling edge, so each value is settled before the sampling edge. The stimulus never leaves the operation select or the operands undriven. Idle cycles are inserted between sweeps and inside the random runs, so the hold property is exercised with a known previous value. The upper operand halves carry random data throughout, so that R11 is tested everywhere and not only in its dedicated section.

// File: rtl/smu_pkg.sv
package smu_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned BYTE_LANES = WORD_W / 8;
   localparam int unsigned HALF_LANES = WORD_W / 16;

   typedef enum logic [2:0] {
      OP_MULU   = 3'd0,
      OP_MULS   = 3'd1,
      OP_MUL16  = 3'd2,
      OP_MUL8   = 3'd3,
      OP_DOT8   = 3'd4,
      OP_CMUL   = 3'd5,
      OP_CMULR  = 3'd6,
      OP_GF8    = 3'd7
   } smu_op_e;

endpackage

// File: rtl/smu_gf8_mul.sv
module smu_gf8_mul #(
   parameter logic [7:0] POLY = 8'h1D
) (
   input  logic [7:0] x,
   input  logic [7:0] y,
   output logic [7:0] p
);

   logic [7:0] acc;
   logic [7:0] sh;

   always_comb begin
      acc = 8'd0;
      sh  = x;
      for (int k = 0; k < 8; k++) begin
         if (y[k]) acc = acc ^ sh;
         sh = sh[7] ? ({sh[6:0], 1'b0} ^ POLY) : {sh[6:0], 1'b0};
      end
      p = acc;
   end

endmodule

// File: rtl/smu_core.sv
module smu_core
   import smu_pkg::*;
#(
   parameter logic [7:0] GF_POLY = 8'h1D
) (
   input  smu_op_e           op,
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   output logic [WORD_W-1:0] lo,
   output logic [WORD_W-1:0] hi
);

   localparam int unsigned DOT_W = 18;

   logic [BYTE_LANES-1:0][15:0] p8;
   logic [BYTE_LANES-1:0][7:0]  pgf;
   logic [HALF_LANES-1:0][31:0] p16;
   logic [31:0] cross_ri;
   logic [31:0] cross_ir;

   // byte lanes: unsigned products and GF(2^8) products
   for (genvar g = 0; g < BYTE_LANES; g++) begin : g_byte
      assign p8[g] = {8'd0, a[8*g +: 8]} * {8'd0, b[8*g +: 8]};
      smu_gf8_mul #(.POLY(GF_POLY)) u_gf (
         .x(a[8*g +: 8]),
         .y(b[8*g +: 8]),
         .p(pgf[g])
      );
   end

   // halfword lanes: signed products, also the same-part complex terms
   for (genvar h = 0; h < HALF_LANES; h++) begin : g_half
      assign p16[h] = $signed({{16{a[16*h+15]}}, a[16*h +: 16]})
                    * $signed({{16{b[16*h+15]}}, b[16*h +: 16]});
   end

   assign cross_ri = $signed({{16{a[31]}}, a[31:16]}) * $signed({{16{b[15]}}, b[15:0]});
   assign cross_ir = $signed({{16{a[15]}}, a[15:0]})  * $signed({{16{b[31]}}, b[31:16]});

   // one 64-bit array serves signed and unsigned full-width multiply
   logic        ext_a, ext_b;
   logic [63:0] wide;
   assign ext_a = (op == OP_MULS) & a[31];
   assign ext_b = (op == OP_MULS) & b[31];
   assign wide  = {{32{ext_a}}, a} * {{32{ext_b}}, b};

   logic signed [32:0] cre, cim;
   assign cre = $signed({p16[1][31], p16[1]}) - $signed({p16[0][31], p16[0]});
   assign cim = $signed({cross_ri[31], cross_ri}) + $signed({cross_ir[31], cross_ir});

   logic [DOT_W-1:0] dot;
   always_comb begin
      dot = '0;
      for (int k = 0; k < BYTE_LANES; k++) dot = dot + {2'b00, p8[k]};
   end

   function automatic logic [15:0] rnd_sat(input logic signed [32:0] v);
      logic signed [33:0] t;
      logic signed [17:0] q;
      t = $signed({v[32], v}) + 34'sd32768;
      q = t[33:16];
      if (q > 18'sd32767)       return 16'h7FFF;
      else if (q < -18'sd32768) return 16'h8000;
      else                      return q[15:0];
   endfunction

   always_comb begin
      lo = '0;
      hi = '0;
      unique case (op)
         OP_MULU, OP_MULS: {hi, lo} = wide;
         OP_MUL16:         {hi, lo} = {p16[1], p16[0]};
         OP_MUL8:          {hi, lo} = {p8[3], p8[2], p8[1], p8[0]};
         OP_DOT8:          lo = {{(WORD_W-DOT_W){1'b0}}, dot};
         OP_CMUL:          {hi, lo} = {cim[31:0], cre[31:0]};
         OP_CMULR:         lo = {rnd_sat(cre), rnd_sat(cim)};
         OP_GF8:           lo = {pgf[3], pgf[2], pgf[1], pgf[0]};
         default:          lo = '0;
      endcase
   end

endmodule

// File: rtl/simd_mul_unit.sv
module simd_mul_unit
   import smu_pkg::*;
#(
   parameter int unsigned SRC_W   = 64,
   parameter logic [7:0]  GF_POLY = 8'h1D
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [2:0]       in_op,
   input  logic [SRC_W-1:0] in_a,
   input  logic [SRC_W-1:0] in_b,
   output logic             out_valid,
   output logic [31:0]      out_lo,
   output logic [31:0]      out_hi
);

   if (SRC_W < WORD_W) begin : g_bad_width
      $error("simd_mul_unit: SRC_W must be at least %0d", WORD_W);
   end
   if (GF_POLY[0] != 1'b1) begin : g_bad_poly
      $error("simd_mul_unit: GF_POLY needs a constant term");
   end

   // operand bits beyond the datapath word are dropped
   if (SRC_W > WORD_W) begin : g_wide_src
      logic unused_upper;
      assign unused_upper = ^{in_a[SRC_W-1:WORD_W], in_b[SRC_W-1:WORD_W]};
   end

   // stage 1: operand capture
   logic              s1_valid;
   smu_op_e           s1_op;
   logic [WORD_W-1:0] s1_a, s1_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_op    <= OP_MULU;
         s1_a     <= '0;
         s1_b     <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_op <= smu_op_e'(in_op);
            s1_a  <= in_a[WORD_W-1:0];
            s1_b  <= in_b[WORD_W-1:0];
         end
      end
   end

   logic [WORD_W-1:0] c_lo, c_hi;

   smu_core #(.GF_POLY(GF_POLY)) u_core (
      .op(s1_op),
      .a (s1_a),
      .b (s1_b),
      .lo(c_lo),
      .hi(c_hi)
   );

   // stage 2: result register, loads only on a completing operation
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_lo    <= '0;
         out_hi    <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) begin
            out_lo <= c_lo;
            out_hi <= c_hi;
         end
      end
   end

endmodule

// File: rtl/smu_chk.sv
module smu_chk #(
   parameter int unsigned SRC_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [2:0]       in_op,
   input logic [SRC_W-1:0] in_a,
   input logic [SRC_W-1:0] in_b,
   input logic             out_valid,
   input logic [31:0]      out_lo,
   input logic [31:0]      out_hi
);

   // cycles since reset release, saturating at 2
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= 2'd0;
      else if (age != 2'd2) age <= age + 2'd1;
   end

   a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

   a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ((age != 2'd0) && !out_valid) |-> ($stable(out_lo) && $stable(out_hi)));

   a_r1_unsigned_product: assert property (@(posedge clk) disable iff (!rst_n)
      ((age == 2'd2) && $past(in_valid && (in_op == 3'd0), 2)) |->
      ({out_hi, out_lo} == ({32'd0, $past(in_a[31:0], 2)} * {32'd0, $past(in_b[31:0], 2)})));

   a_r5_dot_range: assert property (@(posedge clk) disable iff (!rst_n)
      ((age == 2'd2) && out_valid && ($past(in_op, 2) == 3'd4)) |->
      ((out_hi == 32'd0) && (out_lo[31:18] == 14'd0)));

   a_r7_rounded_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((age == 2'd2) && out_valid && ($past(in_op, 2) == 3'd6)) |-> (out_hi == 32'd0));

   a_r8_gf_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((age == 2'd2) && out_valid && ($past(in_op, 2) == 3'd7)) |-> (out_hi == 32'd0));

endmodule

bind simd_mul_unit smu_chk #(.SRC_W(SRC_W)) u_chk (.*);

// File: tb/sim_simd_mul_unit.sv
module sim_simd_mul_unit;

   localparam int CLK_PERIOD = 10;
   localparam int SRC_W = 64;
   localparam logic [7:0] POLY = 8'h1D;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [2:0]       in_op = 3'd0;
   logic [SRC_W-1:0] in_a = '0;
   logic [SRC_W-1:0] in_b = '0;
   logic             out_valid;
   logic [31:0]      out_lo, out_hi;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   simd_mul_unit #(.SRC_W(SRC_W), .GF_POLY(POLY)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
      .out_lo(out_lo), .out_hi(out_hi)
   );

   // ---------------- reference arithmetic ----------------
   function automatic logic [7:0] gf_ref(input logic [7:0] x, input logic [7:0] y);
      logic [14:0] c;
      c = '0;
      for (int i = 0; i < 8; i++) if (y[i]) c = c ^ (15'({x}) << i);
      for (int k = 14; k >= 8; k--)
         if (c[k]) c = c ^ (15'({1'b1, POLY}) << (k - 8));
      return c[7:0];
   endfunction

   function automatic logic [15:0] rsat(input longint v);
      longint q;
      q = (v + 64'sd32768) >>> 16;
      if (q > 32767)  return 16'h7FFF;
      if (q < -32768) return 16'h8000;
      return q[15:0];
   endfunction

   function automatic logic [63:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
      logic [63:0] r;
      longint ar, ai, br, bi, re, im, s;
      r = '0;
      ar = longint'($signed(a[31:16])); ai = longint'($signed(a[15:0]));
      br = longint'($signed(b[31:16])); bi = longint'($signed(b[15:0]));
      re = ar * br - ai * bi;
      im = ar * bi + ai * br;
      case (op)
         3'd0: r = {32'd0, a} * {32'd0, b};
         3'd1: r = longint'($signed(a)) * longint'($signed(b));
         3'd2: begin r[31:0] = 32'(ai * bi); r[63:32] = 32'(ar * br); end
         3'd3: for (int i = 0; i < 4; i++) r[16*i +: 16] = {8'd0, a[8*i +: 8]} * {8'd0, b[8*i +: 8]};
         3'd4: begin
            s = 0;
            for (int i = 0; i < 4; i++) s = s + longint'(a[8*i +: 8]) * longint'(b[8*i +: 8]);
            r[31:0] = 32'(s);
         end
         3'd5: begin r[31:0] = 32'(re); r[63:32] = 32'(im); end
         3'd6: r[31:0] = {rsat(re), rsat(im)};
         default: for (int i = 0; i < 4; i++) r[8*i +: 8] = gf_ref(a[8*i +: 8], b[8*i +: 8]);
      endcase
      return r;
   endfunction

   logic [31:0] seed = 32'h1F2E3D4C;
   function automatic logic [31:0] rnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   // ---------------- checking pipeline ----------------
   bit          pv [2];
   logic [63:0] pexp [2];
   string       preq [2];
   logic [63:0] last_res = '0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // one clock: check what completes now, then present the next operation
   task automatic step(input bit v, input logic [2:0] op, input logic [63:0] a, input logic [63:0] b, input string req);
      @(negedge clk);
      if (pv[1]) begin
         chk(out_valid === 1'b1, "R9", 64'(out_valid), 64'd1);
         chk({out_hi, out_lo} === pexp[1], preq[1], {out_hi, out_lo}, pexp[1]);
         last_res = pexp[1];
      end else begin
         chk(out_valid === 1'b0, "R9", 64'(out_valid), 64'd0);
         chk({out_hi, out_lo} === last_res, "R10", {out_hi, out_lo}, last_res);
      end
      pv[1] = pv[0]; pexp[1] = pexp[0]; preq[1] = preq[0];
      pv[0] = v; pexp[0] = model(op, a[31:0], b[31:0]); preq[0] = req;
      in_valid = v; in_op = op; in_a = a; in_b = b;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 3'd0, {rnd(), rnd()}, {rnd(), rnd()}, "R10");
   endtask

   logic [15:0] c16 [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                            16'h8000, 16'h8001, 16'h1234, 16'hA5A5};

   // all combinations of 16-bit corner values in the four halfword slots
   task automatic sweep16(input logic [2:0] op, input string req);
      for (int i = 0; i < 8; i++)
         for (int j = 0; j < 8; j++)
            for (int k = 0; k < 8; k++)
               for (int l = 0; l < 8; l++)
                  step(1'b1, op, {rnd(), c16[i], c16[j]}, {rnd(), c16[k], c16[l]}, req);
      idle(3);
   endtask

   // every byte pair, four pairs per operation
   task automatic sweep8(input logic [2:0] op, input string req);
      for (int x = 0; x < 256; x++)
         for (int g = 0; g < 64; g++)
            step(1'b1, op, {rnd(), {4{x[7:0]}}},
                 {rnd(), 8'(4*g+3), 8'(4*g+2), 8'(4*g+1), 8'(4*g)}, req);
      idle(3);
   endtask

   task automatic rand_run(input logic [2:0] op, input int n, input string req);
      for (int i = 0; i < n; i++) begin
         step(1'b1, op, {rnd(), rnd()}, {rnd(), rnd()}, req);
         if (i % 5 == 4) idle(1);
      end
      idle(3);
   endtask

   initial begin
      pv[0] = 1'b0; pv[1] = 1'b0;
      pexp[0] = '0; pexp[1] = '0;
      preq[0] = ""; preq[1] = "";
      repeat (3) @(negedge clk);
      // R12: outputs are cleared while reset is held
      chk(out_valid === 1'b0, "R12", 64'(out_valid), 64'd0);
      chk({out_hi, out_lo} === 64'd0, "R12", {out_hi, out_lo}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b0, "R12", 64'(out_valid), 64'd0);
      chk({out_hi, out_lo} === 64'd0, "R12", {out_hi, out_lo}, 64'd0);

      // R1 unsigned full width
      step(1'b1, 3'd0, {32'hDEAD_BEEF, 32'hFFFF_FFFF}, {32'h0, 32'hFFFF_FFFF}, "R1");
      step(1'b1, 3'd0, {32'h0, 32'h8000_0000}, {32'h1, 32'h0000_0002}, "R1");
      rand_run(3'd0, 1500, "R1");
      // R2 signed full width
      step(1'b1, 3'd1, {32'h0, 32'h8000_0000}, {32'h0, 32'h8000_0000}, "R2");
      step(1'b1, 3'd1, {32'h0, 32'hFFFF_FFFF}, {32'h0, 32'h7FFF_FFFF}, "R2");
      rand_run(3'd1, 1500, "R2");
      // R3 dual halfword
      sweep16(3'd2, "R3");
      // R4 quad byte, exhaustive
      sweep8(3'd3, "R4");
      // R5 summed bytes
      step(1'b1, 3'd4, {32'h0, 32'hFFFF_FFFF}, {32'h0, 32'hFFFF_FFFF}, "R5");
      rand_run(3'd4, 1500, "R5");
      // R6 and R7 complex
      sweep16(3'd5, "R6");
      sweep16(3'd6, "R7");
      // R8 Galois field, exhaustive
      sweep8(3'd7, "R8");
      // R11 upper operand bits all ones versus all zeros
      for (int i = 0; i < 500; i++) begin
         logic [31:0] ra, rb;
         logic [2:0]  op;
         ra = rnd(); rb = rnd(); op = 3'(i);
         step(1'b1, op, {32'h0, ra}, {32'h0, rb}, "R11");
         step(1'b1, op, {32'hFFFF_FFFF, ra}, {32'hFFFF_FFFF, rb}, "R11");
      end
      idle(4);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R9 watchdog act=running exp=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule